// File: doc/BRIEF.md
# LIN Controller Command Register

This block holds the command register of a LIN bus controller that can run as bus master or as slave. Software reaches it over a simple indirect register bus made of an address, write data, a write strobe and combinational read data. A write at the register's address becomes either a held mode bit or a one-cycle command strobe for the protocol engine next to it. Some held bits clear themselves when the engine reports an event, such as the end of a frame, an error, a sync break on the bus or a finished wakeup signal.

Two write-only bits give one-cycle clear strobes to the status register, which holds the interrupt flag, and to the error register. Those registers live outside this block. A halt command, used only in slave mode, raises a one-cycle strobe and sets a latched halt level. The latch stays set until the engine reports the next sync break. The current master/slave mode comes in on an input. It decides which commands are accepted.

Top module: `lin_cmd_reg`

## Requirements
- R1: After reset every held output, every strobe and the readback are 0.
- R2: A write takes effect only when `reg_we` is high and `reg_addr` equals `REG_ADDR` (default 8'h08). At any other address a write changes nothing and `reg_rdata` reads 0.
- R3: Writing 1 in bit 3 raises `clr_irq_pulse` for exactly one cycle, in the cycle after the write. Writing 0 in bit 3 leaves it low.
- R4: Writing 1 in bit 2 raises `clr_err_pulse` for exactly one cycle, in the cycle after the write.
- R5: In slave mode, writing 1 in bit 7 raises `halt_pulse` for one cycle and sets `halt_active`. `halt_active` stays high until `evt_sync_break`.
- R6: In master mode, writing 1 in bit 0 sets `start_req`. It stays high until `evt_frame_done` or `evt_error`. Writing 0 in bit 0 does not clear it.
- R7: In slave mode, writing 1 in bit 4 sets `ack_hold`. It stays high until `evt_ack_taken`.
- R8: Writing 1 in bit 1 sets `wake_req`. It stays high until `evt_wake_sent`.
- R9: `sleep_mode` takes the value of bit 6 on every accepted write, and `dir_tx` takes the value of bit 5 (1 means transmit). Both hold between writes.
- R10: While `master_mode` is 1, writes to bits 7 and 4 are ignored. While it is 0, writes to bit 0 are ignored.
- R11: When a clear event arrives in the same cycle as a write of 1 to the bit it clears, the bit ends up 0.
- R12: At the register address, `reg_rdata` is {0, sleep_mode, dir_tx, ack_hold, 0, 0, wake_req, start_req}. Bits 7, 3 and 2 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_addr | input | 8 | Indirect register address |
| reg_wdata | input | 8 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 8 | Readback, 0 when not addressed |
| master_mode | input | 1 | 1 selects master mode, 0 selects slave mode |
| evt_frame_done | input | 1 | Engine reports that a frame finished |
| evt_error | input | 1 | Engine reports an error |
| evt_sync_break | input | 1 | Engine saw a sync break |
| evt_wake_sent | input | 1 | Engine finished sending the wakeup signal |
| evt_ack_taken | input | 1 | Engine consumed the data acknowledge |
| sleep_mode | output | 1 | Software says the bus is asleep |
| dir_tx | output | 1 | Direction of the frame: 1 transmit, 0 receive |
| ack_hold | output | 1 | Pending data acknowledge |
| wake_req | output | 1 | Pending wakeup request |
| start_req | output | 1 | Pending master start request |
| halt_active | output | 1 | Frame processing halted until the next sync break |
| halt_pulse | output | 1 | One-cycle halt strobe |
| clr_irq_pulse | output | 1 | One-cycle clear of the interrupt flag |
| clr_err_pulse | output | 1 | One-cycle clear of the error flags |

## Verification
The assertions take it that the event inputs are single-cycle and synchronous to `clk`. They also take it that `master_mode` changes only in cycles with no write, so that the gating check sees one mode across a write. The stimulus changes inputs only on the falling edge, raises each event for one cycle, and switches mode only while no write is being made. The same-cycle collision cases drive a write and the matching event together in one cycle.

// File: rtl/lin_cmd_reg.sv
module lin_cmd_reg #(
  parameter int          AW       = 8,
  parameter int          DW       = 8,
  parameter logic [AW-1:0] REG_ADDR = 8'h08
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  input  logic          reg_we,
  output logic [DW-1:0] reg_rdata,
  input  logic          master_mode,
  input  logic          evt_frame_done,
  input  logic          evt_error,
  input  logic          evt_sync_break,
  input  logic          evt_wake_sent,
  input  logic          evt_ack_taken,
  output logic          sleep_mode,
  output logic          dir_tx,
  output logic          ack_hold,
  output logic          wake_req,
  output logic          start_req,
  output logic          halt_active,
  output logic          halt_pulse,
  output logic          clr_irq_pulse,
  output logic          clr_err_pulse
);

  localparam int B_HALT  = 7;
  localparam int B_SLEEP = 6;
  localparam int B_DIR   = 5;
  localparam int B_ACK   = 4;
  localparam int B_CIRQ  = 3;
  localparam int B_CERR  = 2;
  localparam int B_WAKE  = 1;
  localparam int B_START = 0;

  logic addr_hit, wr_hit;
  logic set_halt, set_ack, set_start, set_wake;
  logic clr_start;

  assign addr_hit  = (reg_addr == REG_ADDR);
  assign wr_hit    = reg_we && addr_hit;
  assign set_halt  = wr_hit && reg_wdata[B_HALT]  && !master_mode;
  assign set_ack   = wr_hit && reg_wdata[B_ACK]   && !master_mode;
  assign set_start = wr_hit && reg_wdata[B_START] &&  master_mode;
  assign set_wake  = wr_hit && reg_wdata[B_WAKE];
  assign clr_start = evt_frame_done || evt_error;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_mode    <= 1'b0;
      dir_tx        <= 1'b0;
      ack_hold      <= 1'b0;
      wake_req      <= 1'b0;
      start_req     <= 1'b0;
      halt_active   <= 1'b0;
      halt_pulse    <= 1'b0;
      clr_irq_pulse <= 1'b0;
      clr_err_pulse <= 1'b0;
    end else begin
      if (wr_hit) begin
        sleep_mode <= reg_wdata[B_SLEEP];
        dir_tx     <= reg_wdata[B_DIR];
      end
      halt_pulse    <= set_halt;
      clr_irq_pulse <= wr_hit && reg_wdata[B_CIRQ];
      clr_err_pulse <= wr_hit && reg_wdata[B_CERR];

      if (evt_sync_break)    halt_active <= 1'b0;
      else if (set_halt)     halt_active <= 1'b1;

      if (evt_ack_taken)     ack_hold <= 1'b0;
      else if (set_ack)      ack_hold <= 1'b1;

      if (evt_wake_sent)     wake_req <= 1'b0;
      else if (set_wake)     wake_req <= 1'b1;

      if (clr_start)         start_req <= 1'b0;
      else if (set_start)    start_req <= 1'b1;
    end
  end

  assign reg_rdata = addr_hit
    ? {1'b0, sleep_mode, dir_tx, ack_hold, 2'b00, wake_req, start_req}
    : '0;

  a_r3_irq_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    clr_irq_pulse |-> $past(reg_we && reg_addr == REG_ADDR && reg_wdata[B_CIRQ]));

  a_r4_err_strobe_source: assert property (@(posedge clk) disable iff (!rst_n)
    clr_err_pulse |-> $past(reg_we && reg_addr == REG_ADDR && reg_wdata[B_CERR]));

  a_r5_halt_released: assert property (@(posedge clk) disable iff (!rst_n)
    evt_sync_break |=> !halt_active);

  a_r6_start_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_frame_done || evt_error) |=> !start_req);

  a_r7_ack_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    evt_ack_taken |=> !ack_hold);

  a_r8_wake_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    evt_wake_sent |=> !wake_req);

  a_r10_master_no_halt: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && master_mode && !halt_active && !ack_hold) |=> (!halt_active && !ack_hold));

  a_r10_slave_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !master_mode && !start_req) |=> !start_req);

endmodule

// File: tb/test_lin_cmd_reg.sv
module test_lin_cmd_reg;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = '0, reg_wdata = '0;
  logic       reg_we = 1'b0;
  logic [7:0] reg_rdata;
  logic       master_mode = 1'b0;
  logic       evt_frame_done = 1'b0, evt_error = 1'b0, evt_sync_break = 1'b0;
  logic       evt_wake_sent = 1'b0, evt_ack_taken = 1'b0;
  logic       sleep_mode, dir_tx, ack_hold, wake_req, start_req;
  logic       halt_active, halt_pulse, clr_irq_pulse, clr_err_pulse;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lin_cmd_reg i_lin_cmd_reg (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rdata(reg_rdata), .master_mode(master_mode),
    .evt_frame_done(evt_frame_done), .evt_error(evt_error),
    .evt_sync_break(evt_sync_break), .evt_wake_sent(evt_wake_sent),
    .evt_ack_taken(evt_ack_taken), .sleep_mode(sleep_mode), .dir_tx(dir_tx),
    .ack_hold(ack_hold), .wake_req(wake_req), .start_req(start_req),
    .halt_active(halt_active), .halt_pulse(halt_pulse),
    .clr_irq_pulse(clr_irq_pulse), .clr_err_pulse(clr_err_pulse)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one write cycle; returns at the falling edge after the capturing edge
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input string req, input logic [7:0] exp);
    reg_addr = 8'h08;
    #1;
    chk(req, reg_rdata, exp);
  endtask

  task automatic t_reset;
    chk("R1 held outputs", {3'b0, sleep_mode, dir_tx, ack_hold, wake_req, start_req}, 8'h00);
    chk("R1 strobes", {4'b0, halt_active, halt_pulse, clr_irq_pulse, clr_err_pulse}, 8'h00);
    rd("R1 readback", 8'h00);
  endtask

  task automatic t_decode;
    wr(8'h09, 8'h60);
    chk("R2 wrong address ignored", {6'b0, sleep_mode, dir_tx}, 8'h00);
    reg_addr = 8'h09; #1;
    chk("R2 read elsewhere is 0", reg_rdata, 8'h00);
  endtask

  task automatic t_clear_strobes;
    wr(8'h08, 8'h08);
    chk("R3 irq strobe high", {7'b0, clr_irq_pulse}, 8'h01);
    chk("R4 err strobe idle", {7'b0, clr_err_pulse}, 8'h00);
    @(negedge clk);
    chk("R3 irq strobe one cycle", {7'b0, clr_irq_pulse}, 8'h00);
    wr(8'h08, 8'h04);
    chk("R4 err strobe high", {7'b0, clr_err_pulse}, 8'h01);
    chk("R3 bit3 zero no strobe", {7'b0, clr_irq_pulse}, 8'h00);
    @(negedge clk);
    chk("R4 err strobe one cycle", {7'b0, clr_err_pulse}, 8'h00);
  endtask

  task automatic t_halt;
    master_mode = 1'b0;
    wr(8'h08, 8'h80);
    chk("R5 halt strobe", {6'b0, halt_pulse, halt_active}, 8'h03);
    rd("R12 bit7 reads 0", 8'h00);
    @(negedge clk);
    chk("R5 halt held, strobe ends", {6'b0, halt_pulse, halt_active}, 8'h01);
    evt_sync_break = 1'b1; @(negedge clk); evt_sync_break = 1'b0;
    chk("R5 halt released on sync break", {7'b0, halt_active}, 8'h00);
  endtask

  task automatic t_start;
    master_mode = 1'b1;
    wr(8'h08, 8'h01);
    chk("R6 start set", {7'b0, start_req}, 8'h01);
    wr(8'h08, 8'h00);
    chk("R6 write 0 keeps start", {7'b0, start_req}, 8'h01);
    evt_frame_done = 1'b1; @(negedge clk); evt_frame_done = 1'b0;
    chk("R6 frame done clears", {7'b0, start_req}, 8'h00);
    wr(8'h08, 8'h01);
    evt_error = 1'b1; @(negedge clk); evt_error = 1'b0;
    chk("R6 error clears", {7'b0, start_req}, 8'h00);
  endtask

  task automatic t_ack_wake;
    master_mode = 1'b0;
    wr(8'h08, 8'h12);
    chk("R7 ack and R8 wake set", {6'b0, ack_hold, wake_req}, 8'h03);
    rd("R12 readback ack wake", 8'h12);
    evt_ack_taken = 1'b1; @(negedge clk); evt_ack_taken = 1'b0;
    chk("R7 ack cleared", {6'b0, ack_hold, wake_req}, 8'h01);
    evt_wake_sent = 1'b1; @(negedge clk); evt_wake_sent = 1'b0;
    chk("R8 wake cleared", {7'b0, wake_req}, 8'h00);
  endtask

  task automatic t_levels;
    wr(8'h08, 8'h60);
    chk("R9 sleep dir set", {6'b0, sleep_mode, dir_tx}, 8'h03);
    @(negedge clk); @(negedge clk);
    chk("R9 sleep dir held", {6'b0, sleep_mode, dir_tx}, 8'h03);
    wr(8'h08, 8'h20);
    chk("R9 sleep cleared, tx kept", {6'b0, sleep_mode, dir_tx}, 8'h01);
    rd("R12 readback dir", 8'h20);
    wr(8'h08, 8'h00);
  endtask

  task automatic t_gating;
    master_mode = 1'b1;
    wr(8'h08, 8'h90);
    chk("R10 master ignores halt/ack", {5'b0, halt_pulse, halt_active, ack_hold}, 8'h00);
    master_mode = 1'b0;
    wr(8'h08, 8'h01);
    chk("R10 slave ignores start", {7'b0, start_req}, 8'h00);
    rd("R10 readback after ignored writes", 8'h00);
  endtask

  task automatic t_collide;
    master_mode = 1'b1;
    @(negedge clk);
    reg_addr = 8'h08; reg_wdata = 8'h03; reg_we = 1'b1;
    evt_frame_done = 1'b1; evt_wake_sent = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; evt_frame_done = 1'b0; evt_wake_sent = 1'b0;
    chk("R11 start clear wins", {7'b0, start_req}, 8'h00);
    chk("R11 wake clear wins", {7'b0, wake_req}, 8'h00);
    master_mode = 1'b0;
    @(negedge clk);
    reg_wdata = 8'h90; reg_we = 1'b1;
    evt_sync_break = 1'b1; evt_ack_taken = 1'b1;
    @(negedge clk);
    reg_we = 1'b0; evt_sync_break = 1'b0; evt_ack_taken = 1'b0;
    chk("R11 halt release wins", {7'b0, halt_active}, 8'h00);
    chk("R11 ack clear wins", {7'b0, ack_hold}, 8'h00);
  endtask

  task automatic finish_up;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    #1;
    t_reset();
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_decode();
    t_clear_strobes();
    t_halt();
    t_start();
    t_ack_wake();
    t_levels();
    t_gating();
    t_collide();
    finish_up();
  end
endmodule